// File: doc/BRIEF.md
# Asymmetric Four-Slot Decode Grouper

This block sits between an instruction queue front end and the micro-op pipeline. Instructions arrive one per cycle. Their lengths are already known, and each one carries the number of micro-ops it expands to. The block buffers them in a small FIFO and looks at the oldest four entries as a candidate window. Each cycle it forms a decode group from that window.

Lane budgets:
- Only the group head may expand to several micro-ops, using up to the per-cycle budget of four output lanes.
- Every later member of the group must be a single-micro-op instruction.
- Each later member takes one of the remaining lanes.

The group ends early in these cases:
- A multi-micro-op instruction appears behind the head. It then leads the following group.
- The lane budget is spent.
- The window runs out.

Instructions that need more micro-ops than the budget are not decoded in the slots. They are handed to a microcode sequencer. The sequencer streams their micro-ops four per bundle until the count is exhausted. No group is formed while it runs.

Each output bundle is registered and presented on a valid/ready interface as a lane count plus per-lane fields:
- the source tag of the instruction;
- the micro-op index within that instruction;
- a last-of-instruction flag.

A flush input drops everything queued, in flight or streaming.

Top module: `dg_decode_grouper`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A group takes at most four instructions, in queue order. Its lanes are filled in program order: the head's micro-ops first, then one lane per following single-micro-op instruction (index 0, last flag 1).
- R3: A head with u micro-ops, where u is from 1 to 4, occupies lanes 0 to u-1 with indices 0 to u-1. Its last flag is set only on lane u-1.
- R4: An instruction with more than one micro-op at window position 1, 2 or 3 closes the group before it. That instruction heads the next bundle.
- R5: A bundle never exceeds four lanes. A single-micro-op instruction joins the group only while a lane is free, so a head of 4 micro-ops is emitted alone.
- R6: An instruction with more than four micro-ops is streamed by the sequencer as ceil(u/4) consecutive bundles. Every bundle is full except possibly the last. The indices run continuously from 0 to u-1, and the last flag is set only on micro-op u-1.
- R7: While a microcode stream is active, no instruction leaves the queue. The bundle after the final microcode bundle is a normal group formed from the next instructions.
- R8: While out_valid is 1 and out_ready is 0, the bundle stays unchanged and nothing is lost. A new bundle forms only when the register is empty or being accepted.
- R9: A flush makes out_valid 0 in the next cycle. It also empties the queue, aborts any active microcode stream, and drops an instruction offered in the same cycle.
- R10: in_ready is 0 exactly when the queue holds DEPTH (default 8) instructions. Pushes are ignored while it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard queue, stream and output bundle |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | Queue has room |
| in_uops | input | UOPS_W | Micro-op count of the offered instruction (1 or more) |
| in_tag | input | TAG_W | Identifier carried onto its micro-ops |
| out_valid | output | 1 | Bundle present |
| out_ready | input | 1 | Downstream accepts the bundle |
| out_cnt | output | CNT_W | Number of valid lanes, 1 to BUDGET |
| out_tag | output | BUDGET*TAG_W | Per-lane tag, lane k at bits k*TAG_W |
| out_uidx | output | BUDGET*UOPS_W | Per-lane micro-op index within its instruction |
| out_last | output | BUDGET | Per-lane last-of-instruction flag |

## Verification
The embedded properties check the following on every cycle:
- a stalled bundle holds steady;
- a flush empties the output and the sequencer one cycle later;
- the lane count stays within the budget;
- the queue is never popped beyond its occupancy or while microcode streams;
- the sequencer never restarts while busy, and its remaining count shrinks on every step.

The grouping decisions themselves can only be shown by the bench's reference model under its scenarios:
- where a group is cut by a complex instruction or by the lane budget;
- the exact lane order;
- the continuation of indices across microcode bundles;
- the resumption of grouping after a stream;
- the interaction with arrival timing and full-queue back-pressure.

// File: rtl/dg_pkg.sv
package dg_pkg;
  // Where the next output bundle comes from
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_GROUP = 2'd1,
    SRC_UCODE = 2'd2
  } dg_src_e;
endpackage

// File: rtl/dg_queue.sv
// Instruction FIFO exposing its oldest WIN entries as a decode window.
// DEPTH must be a power of two.
module dg_queue #(
  parameter int DEPTH  = 8,
  parameter int WIN    = 4,
  parameter int TAG_W  = 8,
  parameter int UOPS_W = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int POP_W = $clog2(WIN + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          push_valid,
  input  logic [UOPS_W-1:0]             push_uops,
  input  logic [TAG_W-1:0]              push_tag,
  output logic                          not_full,
  input  logic [POP_W-1:0]              pop_n,
  output logic [WIN-1:0]                win_vld,
  output logic [WIN-1:0][UOPS_W-1:0]    win_uops,
  output logic [WIN-1:0][TAG_W-1:0]     win_tag
);

  logic [UOPS_W-1:0] uops_mem [DEPTH];
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [OCC_W-1:0]  occ;
  logic              push_acc;

  assign not_full = (occ != OCC_W'(DEPTH));
  assign push_acc = push_valid && not_full && !flush;

  // storage: write-only port, no reset
  always_ff @(posedge clk) begin
    if (push_acc) begin
      uops_mem[wr_ptr] <= push_uops;
      tag_mem[wr_ptr]  <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_acc) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + PTR_W'(pop_n);
      occ    <= occ + OCC_W'(push_acc) - OCC_W'(pop_n);
    end
  end

  for (genvar j = 0; j < WIN; j++) begin : g_win
    logic [PTR_W-1:0] slot;
    assign slot        = rd_ptr + PTR_W'(j);
    assign win_vld[j]  = occ > OCC_W'(j);
    assign win_uops[j] = uops_mem[slot];
    assign win_tag[j]  = tag_mem[slot];
  end

  // R2
  pop_within_occ_chk: assert property (@(posedge clk) disable iff (rst)
    OCC_W'(pop_n) <= occ);

  // R10
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));

  // R3
  push_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    push_acc |-> push_uops != '0);

endmodule

// File: rtl/dg_grouper.sv
// Combinational group formation over the candidate window.
module dg_grouper #(
  parameter int WIN    = 4,
  parameter int BUDGET = 4,
  parameter int TAG_W  = 8,
  parameter int UOPS_W = 5,
  localparam int CNT_W = $clog2(BUDGET + 1),
  localparam int POP_W = $clog2(WIN + 1)
) (
  input  logic [WIN-1:0]                win_vld,
  input  logic [WIN-1:0][UOPS_W-1:0]    win_uops,
  input  logic [WIN-1:0][TAG_W-1:0]     win_tag,
  output logic                          head_long,
  output logic [POP_W-1:0]              take,
  output logic [CNT_W-1:0]              lane_n,
  output logic [BUDGET-1:0][TAG_W-1:0]  lane_tag,
  output logic [BUDGET-1:0][UOPS_W-1:0] lane_uidx,
  output logic [BUDGET-1:0]             lane_last
);

  logic [WIN-1:0]    admit;
  logic [UOPS_W-1:0] head_u;
  int                n_adm;

  assign head_u    = win_uops[0];
  assign head_long = win_vld[0] && (head_u > UOPS_W'(BUDGET));

  // admit[j]: window entry j joins this group (prefix chain)
  always_comb begin : p_admit
    logic chain;
    chain    = win_vld[0] && !head_long;
    admit    = '0;
    admit[0] = chain;
    for (int j = 1; j < WIN; j++) begin
      chain = chain && win_vld[j] && (win_uops[j] == UOPS_W'(1)) &&
              ((head_u + UOPS_W'(j - 1)) < UOPS_W'(BUDGET));
      admit[j] = chain;
    end
  end

  always_comb begin
    n_adm = 0;
    for (int j = 0; j < WIN; j++) begin
      if (admit[j]) n_adm = n_adm + 1;
    end
    take   = head_long ? POP_W'(1) : POP_W'(n_adm);
    lane_n = admit[0] ? (CNT_W'(head_u) + CNT_W'(n_adm - 1)) : '0;
  end

  // Lane steering: head fills lanes 0..u-1, simple j lands on lane u+j-1
  always_comb begin
    lane_tag  = '0;
    lane_uidx = '0;
    lane_last = '0;
    for (int k = 0; k < BUDGET; k++) begin
      if (admit[0] && (UOPS_W'(k) < head_u)) begin
        lane_tag[k]  = win_tag[0];
        lane_uidx[k] = UOPS_W'(k);
        lane_last[k] = (UOPS_W'(k + 1) == head_u);
      end
      for (int j = 1; j < WIN; j++) begin
        if (admit[j] && ((head_u + UOPS_W'(j - 1)) == UOPS_W'(k))) begin
          lane_tag[k]  = win_tag[j];
          lane_uidx[k] = '0;
          lane_last[k] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dg_ucode_seq.sv
// Count-driven microcode stream: emits up to BUDGET micro-ops per step.
module dg_ucode_seq #(
  parameter int BUDGET = 4,
  parameter int TAG_W  = 8,
  parameter int UOPS_W = 5,
  localparam int CNT_W = $clog2(BUDGET + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          start,
  input  logic [UOPS_W-1:0]             start_uops,
  input  logic [TAG_W-1:0]              start_tag,
  input  logic                          advance,
  output logic                          active,
  output logic [CNT_W-1:0]              emit_n,
  output logic [BUDGET-1:0][TAG_W-1:0]  emit_tag,
  output logic [BUDGET-1:0][UOPS_W-1:0] emit_uidx,
  output logic [BUDGET-1:0]             emit_last
);

  logic              act_q;
  logic [UOPS_W-1:0] rem_q, idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [UOPS_W-1:0] src_rem, src_idx, chunk;
  logic [TAG_W-1:0]  src_tag;
  logic              final_chunk;

  assign active = act_q;

  always_comb begin
    src_rem     = act_q ? rem_q : start_uops;
    src_idx     = act_q ? idx_q : '0;
    src_tag     = act_q ? tag_q : start_tag;
    final_chunk = (src_rem <= UOPS_W'(BUDGET));
    chunk       = final_chunk ? src_rem : UOPS_W'(BUDGET);
    emit_n      = CNT_W'(chunk);
    emit_tag    = '0;
    emit_uidx   = '0;
    emit_last   = '0;
    for (int k = 0; k < BUDGET; k++) begin
      if (UOPS_W'(k) < chunk) begin
        emit_tag[k]  = src_tag;
        emit_uidx[k] = src_idx + UOPS_W'(k);
        emit_last[k] = final_chunk && (UOPS_W'(k + 1) == chunk);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      act_q <= 1'b0;
      rem_q <= '0;
      idx_q <= '0;
      tag_q <= '0;
    end else if (start || advance) begin
      act_q <= !final_chunk;
      rem_q <= src_rem - chunk;
      idx_q <= src_idx + chunk;
      tag_q <= src_tag;
    end
  end

  // R6
  start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !act_q);

  // R6
  rem_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && advance) |=> (!act_q || (rem_q < $past(rem_q))));

  // R9
  flush_abort_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !act_q);

endmodule

// File: rtl/dg_decode_grouper.sv
module dg_decode_grouper import dg_pkg::*; #(
  parameter int WIN    = 4,
  parameter int BUDGET = 4,
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 8,
  parameter int UOPS_W = 5,
  localparam int CNT_W = $clog2(BUDGET + 1),
  localparam int POP_W = $clog2(WIN + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [UOPS_W-1:0]         in_uops,
  input  logic [TAG_W-1:0]          in_tag,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [CNT_W-1:0]          out_cnt,
  output logic [BUDGET*TAG_W-1:0]   out_tag,
  output logic [BUDGET*UOPS_W-1:0]  out_uidx,
  output logic [BUDGET-1:0]         out_last
);

  logic [WIN-1:0]                win_vld;
  logic [WIN-1:0][UOPS_W-1:0]    win_uops;
  logic [WIN-1:0][TAG_W-1:0]     win_tag;
  logic                          g_long;
  logic [POP_W-1:0]              g_take, pop_n;
  logic [CNT_W-1:0]              g_n, s_n;
  logic [BUDGET-1:0][TAG_W-1:0]  g_tag, s_tag;
  logic [BUDGET-1:0][UOPS_W-1:0] g_uidx, s_uidx;
  logic [BUDGET-1:0]             g_last, s_last;
  logic                          s_active, s_start, s_adv, load;
  dg_src_e                       src;

  dg_queue #(.DEPTH(DEPTH), .WIN(WIN), .TAG_W(TAG_W), .UOPS_W(UOPS_W)) u_queue (
    .clk(clk), .rst(rst), .flush(flush),
    .push_valid(in_valid), .push_uops(in_uops), .push_tag(in_tag),
    .not_full(in_ready), .pop_n(pop_n),
    .win_vld(win_vld), .win_uops(win_uops), .win_tag(win_tag)
  );

  dg_grouper #(.WIN(WIN), .BUDGET(BUDGET), .TAG_W(TAG_W), .UOPS_W(UOPS_W)) u_group (
    .win_vld(win_vld), .win_uops(win_uops), .win_tag(win_tag),
    .head_long(g_long), .take(g_take), .lane_n(g_n),
    .lane_tag(g_tag), .lane_uidx(g_uidx), .lane_last(g_last)
  );

  dg_ucode_seq #(.BUDGET(BUDGET), .TAG_W(TAG_W), .UOPS_W(UOPS_W)) u_seq (
    .clk(clk), .rst(rst), .flush(flush),
    .start(s_start), .start_uops(win_uops[0]), .start_tag(win_tag[0]),
    .advance(s_adv), .active(s_active),
    .emit_n(s_n), .emit_tag(s_tag), .emit_uidx(s_uidx), .emit_last(s_last)
  );

  // A new bundle may be formed when the output register is free or draining
  assign load = !out_valid || out_ready;

  always_comb begin
    src = SRC_IDLE;
    if (!flush && load) begin
      if (s_active || g_long) src = SRC_UCODE;
      else if (g_n != '0)     src = SRC_GROUP;
    end
  end

  assign s_start = (src == SRC_UCODE) && !s_active;
  assign s_adv   = (src == SRC_UCODE) && s_active;
  assign pop_n   = (src == SRC_GROUP) ? g_take :
                   (s_start ? POP_W'(1) : '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid <= 1'b0;
      out_cnt   <= '0;
      out_tag   <= '0;
      out_uidx  <= '0;
      out_last  <= '0;
    end else if (load) begin
      out_valid <= (src != SRC_IDLE);
      case (src)
        SRC_GROUP: begin
          out_cnt  <= g_n;
          out_tag  <= g_tag;
          out_uidx <= g_uidx;
          out_last <= g_last;
        end
        SRC_UCODE: begin
          out_cnt  <= s_n;
          out_tag  <= s_tag;
          out_uidx <= s_uidx;
          out_last <= s_last;
        end
        default: begin
          out_cnt  <= '0;
          out_tag  <= '0;
          out_uidx <= '0;
          out_last <= '0;
        end
      endcase
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_cnt) && $stable(out_tag) &&
       $stable(out_uidx) && $stable(out_last)));

  // R9
  flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  // R5
  lane_budget_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cnt != '0 && out_cnt <= CNT_W'(BUDGET)));

  // R7
  no_pop_in_stream_chk: assert property (@(posedge clk) disable iff (rst)
    s_active |-> pop_n == '0);

endmodule

// File: tb/tb_dg_decode_grouper.sv
module tb_dg_decode_grouper;
  localparam int CLK_PERIOD = 10;
  localparam int WIN    = 4;
  localparam int BUDGET = 4;
  localparam int DEPTH  = 8;
  localparam int TAG_W  = 8;
  localparam int UOPS_W = 5;
  localparam int CNT_W  = $clog2(BUDGET + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [UOPS_W-1:0] in_uops = '0;
  logic [TAG_W-1:0]  in_tag = '0;
  logic [CNT_W-1:0]  out_cnt;
  logic [BUDGET*TAG_W-1:0]  out_tag;
  logic [BUDGET*UOPS_W-1:0] out_uidx;
  logic [BUDGET-1:0]        out_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  dg_decode_grouper #(.WIN(WIN), .BUDGET(BUDGET), .DEPTH(DEPTH),
                      .TAG_W(TAG_W), .UOPS_W(UOPS_W)) dut (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_uops(in_uops), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_cnt(out_cnt),
    .out_tag(out_tag), .out_uidx(out_uidx), .out_last(out_last)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  int    mq_u[$];
  int    mq_t[$];
  bit    ex_v = 0;
  int    ex_n = 0;
  int    ex_t[BUDGET];
  int    ex_i[BUDGET];
  bit    ex_l[BUDGET];
  string ex_req = "R1";
  bit    ms_act = 0;
  int    ms_rem = 0, ms_idx = 0, ms_tag = 0;
  bit    uc_done = 0;
  int    next_tag = 0;

  // Advance the model across one clock edge; returns 1 if the push is taken
  function automatic bit model_step(bit fl, bit iv, int iu, int it, bit rdy);
    bit room = (mq_u.size() < DEPTH);
    if (fl) begin
      mq_u.delete(); mq_t.delete();
      ms_act = 0; ex_v = 0; ex_n = 0; uc_done = 0; ex_req = "R9";
      return 0;
    end
    if (!ex_v || rdy) begin
      ex_v = 0; ex_n = 0;
      for (int k = 0; k < BUDGET; k++) begin ex_t[k] = 0; ex_i[k] = 0; ex_l[k] = 0; end
      if (ms_act || (mq_u.size() > 0 && mq_u[0] > BUDGET)) begin
        int rem, idx, tg, ch;
        if (ms_act) begin rem = ms_rem; idx = ms_idx; tg = ms_tag; end
        else begin rem = mq_u.pop_front(); tg = mq_t.pop_front(); idx = 0; end
        ch = (rem > BUDGET) ? BUDGET : rem;
        for (int k = 0; k < ch; k++) begin
          ex_t[k] = tg; ex_i[k] = idx + k; ex_l[k] = (rem <= BUDGET) && (k == ch - 1);
        end
        ms_act = (rem > BUDGET); ms_rem = rem - ch; ms_idx = idx + ch; ms_tag = tg;
        if (!ms_act) uc_done = 1;
        ex_v = 1; ex_n = ch; ex_req = "R6";
      end else if (mq_u.size() > 0) begin
        int u0, t0, n, taken;
        u0 = mq_u.pop_front(); t0 = mq_t.pop_front();
        for (int k = 0; k < u0; k++) begin ex_t[k] = t0; ex_i[k] = k; ex_l[k] = (k == u0 - 1); end
        n = u0; taken = 1;
        while (taken < WIN && mq_u.size() > 0 && mq_u[0] == 1 && n < BUDGET) begin
          void'(mq_u.pop_front());
          ex_t[n] = mq_t.pop_front(); ex_i[n] = 0; ex_l[n] = 1;
          n++; taken++;
        end
        ex_req = (u0 > 1) ? "R3" : "R2";
        if (taken < WIN && mq_u.size() > 0 && mq_u[0] != 1 && n < BUDGET) ex_req = "R4";
        else if (n == BUDGET && taken < WIN && mq_u.size() > 0 && mq_u[0] == 1) ex_req = "R5";
        if (uc_done) ex_req = "R7";
        uc_done = 0;
        ex_v = 1; ex_n = n;
      end
    end else begin
      ex_req = "R8";
    end
    if (iv && room) begin
      mq_u.push_back(iu); mq_t.push_back(it);
      return 1;
    end
    return 0;
  endfunction

  task automatic check_outputs();
    bit bad = 0;
    n_cmp++;
    if (in_ready !== (mq_u.size() < DEPTH)) begin
      $display("FAIL R10 in_ready actual=%0b expected=%0b", in_ready, (mq_u.size() < DEPTH));
      n_bad++;
    end
    n_cmp++;
    if (out_valid !== ex_v) begin
      $display("FAIL %s out_valid actual=%0b expected=%0b", ex_req, out_valid, ex_v);
      bad = 1;
    end else if (ex_v) begin
      if (int'(out_cnt) != ex_n) begin
        $display("FAIL %s out_cnt actual=%0d expected=%0d", ex_req, out_cnt, ex_n);
        bad = 1;
      end
      for (int k = 0; k < BUDGET; k++) begin
        if (k < ex_n) begin
          if (int'(out_tag[k*TAG_W +: TAG_W]) != ex_t[k] ||
              int'(out_uidx[k*UOPS_W +: UOPS_W]) != ex_i[k] ||
              out_last[k] !== ex_l[k]) begin
            $display("FAIL %s lane%0d tag/idx/last actual=%0d/%0d/%0b expected=%0d/%0d/%0b",
                     ex_req, k, out_tag[k*TAG_W +: TAG_W], out_uidx[k*UOPS_W +: UOPS_W],
                     out_last[k], ex_t[k], ex_i[k], ex_l[k]);
            bad = 1;
          end
        end
      end
    end
    if (bad) n_bad++;
  endtask

  task automatic cycle(bit fl, bit iv, int iu, bit rdy);
    bit took;
    flush = fl; in_valid = iv; in_uops = UOPS_W'(iu);
    in_tag = TAG_W'(next_tag); out_ready = rdy;
    took = model_step(fl, iv, iu, next_tag, rdy);
    if (took) next_tag = (next_tag + 1) % 256;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic push1(int u, bit rdy);
    cycle(1'b0, 1'b1, u, rdy);
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1, rdy);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    n_cmp++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      $display("FAIL R1 out_valid/in_ready actual=%0b/%0b expected=0/1", out_valid, in_ready);
      n_bad++;
    end

    // R2 R8: simples arrive behind a stalled output
    for (int i = 0; i < 6; i++) push1(1, 1'b0);
    idle(2, 1'b0);
    idle(4, 1'b1);
    // R4: complex at position 1 cuts the group
    push1(2, 1'b0); push1(1, 1'b0); push1(3, 1'b0); push1(1, 1'b0); push1(1, 1'b0);
    idle(5, 1'b1);
    // R3 R5: lane budget limits simples; head of 4 alone
    push1(3, 1'b0); push1(1, 1'b0); push1(1, 1'b0); push1(4, 1'b0); push1(1, 1'b0);
    idle(5, 1'b1);
    // R6 R7: microcode streams of 9, 8 and 5 with simples between
    push1(9, 1'b0); push1(1, 1'b0); push1(1, 1'b0); push1(8, 1'b0); push1(5, 1'b0); push1(1, 1'b0);
    idle(12, 1'b1);
    // R8: stalls in the middle of a stream
    push1(13, 1'b1); push1(1, 1'b0); idle(2, 1'b0); idle(6, 1'b1);
    // R9: flush mid-stream, with a push in the same cycle
    push1(13, 1'b1); push1(1, 1'b1); push1(1, 1'b1);
    cycle(1'b1, 1'b1, 1, 1'b1);
    push1(1, 1'b1); push1(2, 1'b1); idle(4, 1'b1);
    // R10: fill the queue while stalled
    for (int i = 0; i < DEPTH + 4; i++) push1(2, 1'b0);
    idle(10, 1'b1);

    // constrained random mix
    for (int c = 0; c < 6000; c++) begin
      int r, u;
      bit fl, iv, rdy;
      r = int'($urandom % 100);
      u = (r < 60) ? 1 : (r < 85) ? 2 + int'($urandom % 3) : 5 + int'($urandom % 10);
      iv  = ($urandom % 100) < 70;
      rdy = ($urandom % 100) < 75;
      fl  = ($urandom % 100) < 2;
      cycle(fl, iv, u, rdy);
    end
    idle(20, 1'b1);

    summary();
    $finish;
  end
endmodule